// File: doc/BRIEF.md
# Dual-Speed I2C Serial Clock Generator

This block produces the serial clock for an I2C bus master. The clock alternates between a released (high) phase and a driven-low phase. The length of each phase is a programmable number of input clock cycles. There are two pairs of phase counts, one for standard-rate operation and one for fast-rate operation, and a two-bit speed code picks the pair. Software typically programs each count as the input clock frequency in kHz multiplied by the target phase time, rounded down, plus one. For standard rate the targets are about 4.0 µs high and 4.7 µs low. For fast rate they are about 0.6 µs high and 1.3 µs low.

The generator watches the real line level. After it releases the clock, a slave may keep the line low to stretch the bit. The high-phase count does not advance until the line is seen high. Each falling and rising edge of the generated clock comes with a one-cycle strobe, so that a byte engine can place its data-line changes. Start and stop conditions and data-line handling belong to other blocks.

The counts and the speed code are captured only while the block is disabled. The captured values stay fixed for the whole enabled run.

Top module: `scl_clk_gen`

## Requirements
- R1: While `enable` is low at a clock edge, after that edge `scl_o` is 1 (released) and `fall_stb` and `rise_stb` are 0. This also holds directly after reset.
- R2: Speed code 2 selects the fast count pair (`fast_high_cnt`, `fast_low_cnt`). Codes 0, 1 and 3 select the standard pair (`std_high_cnt`, `std_low_cnt`).
- R3: Each low phase lasts exactly L input cycles, where L is the selected low count, and a count of 0 is treated as 1. So the stamp of `rise_stb` minus the stamp of the preceding `fall_stb` equals L.
- R4: Each high phase lasts H cycles in which `scl_in` is 1, where H is the selected high count and 0 is treated as 1. Cycles in which `scl_in` is 0 during the high phase do not count. So the time from `rise_stb` to the next `fall_stb` is H plus the number of stretched cycles.
- R5: `fall_stb` is 1 for exactly the first cycle in which `scl_o` is 0, and `rise_stb` is 1 for exactly the first cycle in which `scl_o` is 1 again. The two strobes are never high together.
- R6: Counts and speed code are sampled only while disabled. Changes made while enabled have no effect on phase lengths until the next enable.
- R7: If `enable` is first seen high at clock edge k, the first `fall_stb` appears after edge k+H, where H is the effective high count.
- R8: Dropping `enable` in the middle of either phase releases `scl_o` after the next edge, and no strobe is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; all counts are in its cycles |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the generator when high; idles and captures configuration when low |
| speed_sel | input | 2 | Speed code: 2 = fast pair, any other value = standard pair |
| std_high_cnt | input | 16 | Standard-rate high-phase length in cycles |
| std_low_cnt | input | 16 | Standard-rate low-phase length in cycles |
| fast_high_cnt | input | 16 | Fast-rate high-phase length in cycles |
| fast_low_cnt | input | 16 | Fast-rate low-phase length in cycles |
| scl_in | input | 1 | Sensed serial clock line level, synchronous to `clk` (0 while held low by any device) |
| scl_o | output | 1 | Clock drive: 1 = released, 0 = pull low |
| fall_stb | output | 1 | One-cycle strobe on the high-to-low transition |
| rise_stb | output | 1 | One-cycle strobe on the low-to-high transition |

## Verification
The hardest case to reach from the ports is a stretch that starts exactly when the generator releases the line. In that case the high-phase counter must stall for a known number of cycles and then run its full length. The bench models the wired-AND line: `scl_in` is `scl_o` ANDed with a slave hold. On each observed rising strobe the bench asserts the hold for a chosen number of cycles, and then expects the next falling strobe at that many cycles past the nominal high count. A second corner is a configuration change in the middle of a run. The bench rewrites counts and speed code while enabled and keeps expecting the lengths captured at enable, until it disables and restarts.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } scl_phase_e;

    // speed code that picks the fast count pair; all others pick standard
    localparam logic [1:0] SPD_FAST = 2'd2;

endpackage

// File: rtl/scl_cfg_latch.sv
module scl_cfg_latch
    import scl_gen_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [1:0]    speed_sel,
    input  logic [CW-1:0] std_hi,
    input  logic [CW-1:0] std_lo,
    input  logic [CW-1:0] fst_hi,
    input  logic [CW-1:0] fst_lo,
    output logic [CW-1:0] hi_cnt,
    output logic [CW-1:0] lo_cnt
);

    typedef struct packed {
        logic [CW-1:0] hi;
        logic [CW-1:0] lo;
    } pair_t;

    pair_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (!enable) begin
            if (speed_sel == SPD_FAST) begin
                cfg_d.hi = fst_hi;
                cfg_d.lo = fst_lo;
            end else begin
                cfg_d.hi = std_hi;
                cfg_d.lo = std_lo;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign hi_cnt = cfg_q.hi;
    assign lo_cnt = cfg_q.lo;

    // configuration is frozen for the whole enabled run
    p_cfg_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> ($stable(cfg_q.hi) && $stable(cfg_q.lo)));

endmodule

// File: rtl/scl_phase_cnt.sv
module scl_phase_cnt #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    input  logic [CW-1:0] limit,
    output logic          expire,
    output logic [CW-1:0] count
);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] lim_eff;
    logic [CW:0]   nxt_w;

    always_comb begin
        lim_eff = (limit == '0) ? {{(CW-1){1'b0}}, 1'b1} : limit;
        nxt_w   = {1'b0, cnt_q} + {{CW{1'b0}}, 1'b1};
        expire  = step && (nxt_w >= {1'b0, lim_eff});
        cnt_d   = cnt_q;
        if (clear || expire) cnt_d = '0;
        else if (step)       cnt_d = nxt_w[CW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    // the running count never reaches the effective phase length
    p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < lim_eff);

endmodule

// File: rtl/scl_clk_gen.sv
module scl_clk_gen
    import scl_gen_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [1:0]    speed_sel,
    input  logic [CW-1:0] std_high_cnt,
    input  logic [CW-1:0] std_low_cnt,
    input  logic [CW-1:0] fast_high_cnt,
    input  logic [CW-1:0] fast_low_cnt,
    input  logic          scl_in,
    output logic          scl_o,
    output logic          fall_stb,
    output logic          rise_stb
);

    typedef struct packed {
        scl_phase_e phase;
        logic       scl;
        logic       fall;
        logic       rise;
    } gen_t;

    gen_t st_d, st_q;

    logic [CW-1:0] hi_cnt, lo_cnt, cur_lim, cnt_val;
    logic          cnt_clear, cnt_step, cnt_expire;

    scl_cfg_latch #(.CW(CW)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .speed_sel (speed_sel),
        .std_hi    (std_high_cnt),
        .std_lo    (std_low_cnt),
        .fst_hi    (fast_high_cnt),
        .fst_lo    (fast_low_cnt),
        .hi_cnt    (hi_cnt),
        .lo_cnt    (lo_cnt)
    );

    always_comb begin
        cur_lim   = (st_q.phase == PH_LOW) ? lo_cnt : hi_cnt;
        cnt_clear = !enable || (st_q.phase == PH_IDLE);
        // high phase only advances while the line is really high (stretch)
        cnt_step  = enable && (((st_q.phase == PH_HIGH) && scl_in) ||
                               (st_q.phase == PH_LOW));
    end

    scl_phase_cnt #(.CW(CW)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (cnt_clear),
        .step   (cnt_step),
        .limit  (cur_lim),
        .expire (cnt_expire),
        .count  (cnt_val)
    );

    always_comb begin
        st_d      = st_q;
        st_d.fall = 1'b0;
        st_d.rise = 1'b0;
        if (!enable) begin
            st_d.phase = PH_IDLE;
            st_d.scl   = 1'b1;
        end else begin
            case (st_q.phase)
                PH_IDLE: begin
                    st_d.phase = PH_HIGH;
                    st_d.scl   = 1'b1;
                end
                PH_HIGH: if (cnt_expire) begin
                    st_d.phase = PH_LOW;
                    st_d.scl   = 1'b0;
                    st_d.fall  = 1'b1;
                end
                PH_LOW: if (cnt_expire) begin
                    st_d.phase = PH_HIGH;
                    st_d.scl   = 1'b1;
                    st_d.rise  = 1'b1;
                end
                default: begin
                    st_d.phase = PH_IDLE;
                    st_d.scl   = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
            st_q.scl   <= 1'b1;
            st_q.fall  <= 1'b0;
            st_q.rise  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign scl_o    = st_q.scl;
    assign fall_stb = st_q.fall;
    assign rise_stb = st_q.rise;

    p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (scl_o && !fall_stb && !rise_stb));

    p_fall_marks_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |-> (!scl_o && $past(scl_o)));

    p_rise_marks_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |-> (scl_o && !$past(scl_o)));

    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(fall_stb && rise_stb));

    p_stretch_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && st_q.phase == PH_HIGH && !scl_in) |=> ($stable(cnt_val) || !enable));

endmodule

// File: tb/test_scl_clk_gen.sv
module test_scl_clk_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [1:0]  speed_sel = 2'd1;
    logic [15:0] sh = 16'd3, sl = 16'd3, fh = 16'd2, fl = 16'd2;
    logic        scl_in;
    logic        scl_o, fall_stb, rise_stb;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench-side expectations, set at each enable
    int exp_hi = 1, exp_lo = 1, stretch_cfg = 0, s_used = 0;
    int hold_cnt = 0;
    int t_fall = 0, t_rise = 0, en_stamp = 0;
    bit have_fall = 0, have_rise = 0, mid_changed = 0;
    bit en_q = 0, en_prev = 0, prev_scl = 1;

    assign scl_in = scl_o & (hold_cnt == 0);

    always #2.5 clk = ~clk;

    scl_clk_gen i_scl_clk_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .speed_sel     (speed_sel),
        .std_high_cnt  (sh),
        .std_low_cnt   (sl),
        .fast_high_cnt (fh),
        .fast_low_cnt  (fl),
        .scl_in        (scl_in),
        .scl_o         (scl_o),
        .fall_stb      (fall_stb),
        .rise_stb      (rise_stb)
    );

    function automatic int eff(input logic [15:0] c);
        return (c == 16'd0) ? 1 : int'(c);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        en_q <= enable;
        if (cyc > 150000 && !done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // monitor: samples outputs away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (hold_cnt > 0) hold_cnt--;
            if (!en_q) begin
                hold_cnt = 0;
                have_fall = 0;
                have_rise = 0;
                if (en_prev)
                    chk(scl_o && !fall_stb && !rise_stb, "R8 release on disable",
                        {fall_stb, rise_stb, scl_o}, 1);
                else
                    chk(scl_o && !fall_stb && !rise_stb, "R1 idle released",
                        {fall_stb, rise_stb, scl_o}, 1);
            end else begin
                if (fall_stb)
                    chk(!scl_o && prev_scl && !rise_stb, "R5 fall strobe placement",
                        {prev_scl, scl_o}, 2);
                if (rise_stb)
                    chk(scl_o && !prev_scl && !fall_stb, "R5 rise strobe placement",
                        {prev_scl, scl_o}, 1);
                if (fall_stb) begin
                    if (have_rise)
                        chk(cyc - t_rise == exp_hi + s_used,
                            mid_changed ? "R6 high length frozen" : "R4 high length with stretch",
                            cyc - t_rise, exp_hi + s_used);
                    else
                        chk(cyc - en_stamp == exp_hi + 1, "R2,R7 first fall after enable",
                            cyc - en_stamp, exp_hi + 1);
                    t_fall = cyc;
                    have_fall = 1;
                end
                if (rise_stb) begin
                    if (have_fall)
                        chk(cyc - t_fall == exp_lo,
                            mid_changed ? "R6 low length frozen" : "R3 low length",
                            cyc - t_fall, exp_lo);
                    t_rise = cyc;
                    have_rise = 1;
                    s_used = stretch_cfg;
                    hold_cnt = stretch_cfg;
                end
            end
            prev_scl = scl_o;
            en_prev = en_q;
        end
    end

    task automatic start_run(input logic [1:0] spd, input logic [15:0] a, input logic [15:0] b,
                             input logic [15:0] c, input logic [15:0] d, input int s);
        @(negedge clk);
        enable = 1'b0;
        speed_sel = spd;
        sh = a; sl = b; fh = c; fl = d;
        stretch_cfg = s;
        mid_changed = 0;
        @(negedge clk);
        @(negedge clk);
        // R2: code 2 picks the fast pair, all other codes the standard pair
        exp_hi = (spd == 2'd2) ? eff(c) : eff(a);
        exp_lo = (spd == 2'd2) ? eff(d) : eff(b);
        enable = 1'b1;
        en_stamp = cyc;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic stop_run();
        @(negedge clk);
        enable = 1'b0;
        wait_cycles(3);
    endtask

    initial begin
        void'($urandom(32'd4242));
        wait_cycles(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk(scl_o && !fall_stb && !rise_stb, "R1 reset state", {fall_stb, rise_stb, scl_o}, 1);

        // directed: typical standard rate at 50 MHz (201 high, 236 low)
        start_run(2'd1, 16'd201, 16'd236, 16'd31, 16'd66, 0);
        wait_cycles(2 * (201 + 236) + 20);
        stop_run();
        // directed: fast rate with the same registers, stretched by 3
        start_run(2'd2, 16'd201, 16'd236, 16'd31, 16'd66, 3);
        wait_cycles(3 * (31 + 66 + 3) + 20);
        stop_run();
        // directed: code 3 and code 0 fall back to standard
        start_run(2'd3, 16'd5, 16'd7, 16'd2, 16'd2, 0);
        wait_cycles(50);
        stop_run();
        start_run(2'd0, 16'd4, 16'd3, 16'd9, 16'd9, 1);
        wait_cycles(50);
        stop_run();
        // directed: zero counts behave as one cycle
        start_run(2'd1, 16'd0, 16'd0, 16'd0, 16'd0, 0);
        wait_cycles(20);
        stop_run();
        // directed R6: change configuration mid-run, lengths stay frozen
        start_run(2'd1, 16'd6, 16'd4, 16'd2, 16'd3, 0);
        wait_cycles(15);
        mid_changed = 1;
        speed_sel = 2'd2;
        sh = 16'd20; sl = 16'd20;
        wait_cycles(60);
        stop_run();

        // random runs, each ending with a disable at an arbitrary point
        for (int i = 0; i < 40; i++) begin
            logic [1:0]  spd;
            logic [15:0] a, b, c, d;
            int s, per;
            spd = 2'($urandom % 4);
            a = 16'($urandom % 12); b = 16'($urandom % 12);
            c = 16'($urandom % 12); d = 16'($urandom % 12);
            s = int'($urandom % 4);
            start_run(spd, a, b, c, d, s);
            per = exp_hi + exp_lo + s;
            wait_cycles(2 * per + 4);
            if ($urandom % 2 == 1) begin
                mid_changed = 1;
                sh = 16'($urandom % 12); fh = 16'($urandom % 12);
                sl = 16'($urandom % 12); fl = 16'($urandom % 12);
                speed_sel = 2'($urandom % 4);
            end
            wait_cycles(per + int'($urandom % 20));
            stop_run();
        end

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule